// File: doc/BRIEF.md
# Compressed program-counter trace buffer

The block records a stream of 18-bit program-counter values into a circular line memory so that a debugger can later reconstruct the recent program flow. Every stored line is 20 bits wide. Tracing starts with an arm pulse. From then on, every cycle in which the PC-valid strobe is high may produce memory writes. Recording ends when an end-aligned trigger has been seen and the next line write completes. The write pointer then freezes and the memory is read through a combinational read port.

The block has two storage formats, chosen by a mode input that stays stable while tracing:

- **Normal format.** Each captured PC takes one line. The line holds the full address and two flags: whether the address is a destination, and whether it is a vector target.
- **Compressed format.** The block keeps a base address. While the upper twelve PC bits stay equal to those of the base, only the low six bits of each PC are packed, up to three per line. Each such line carries a 2-bit tag giving its offset count. A PC outside the base's 64-address window first flushes the partly filled line, then writes a new full base line in the same cycle.

Because the memory wraps, old base lines can be overwritten. Compressed lines that follow the pointer then lose their base, and reconstruction must start at the first base line found after the pointer.

Top module: `pc_trace_buf`

## Requirements
- R1: After reset, `wr_ptr_o` is 0, `rollover_o` is 0 and `active_o` is 0. Every memory line reads as zero.
- R2: Normal-format line layout: bit 19 is the destination flag, bit 18 is the vector flag, and bits 17:0 are the PC. A set vector flag forces bit 19 to 1.
- R3: In compressed format, the first PC after arming is written as a base line. A base line has tag 00 in bits 19:18 and the full PC in bits 17:0.
- R4: A PC whose bits 17:6 equal those of the current base adds its bits 5:0 to the open line. Offsets fill field 0 (bits 5:0), then field 1 (bits 11:6), then field 2 (bits 17:12). The third offset writes the line with tag 11 in the same cycle.
- R5: A PC whose bits 17:6 differ from the base causes two things in one cycle. Any open line is written first, with tag 01 or 10 for one or two offsets and unused fields zero. The new base line is written to the following slot.
- R6: `wr_ptr_o` gives the next slot to be written. It advances by the number of lines written in a cycle (0, 1 or 2) and wraps from DEPTH-1 to 0. After a wrap it points at the oldest surviving line.
- R7: `rollover_o` is set by the first pointer wrap. It stays set until the next arm pulse clears it.
- R8: Once an end-aligned trigger is seen, recording stops after the next cycle that writes a line, including that cycle's writes. After that, `active_o` is 0, the pointer freezes, and further PCs and triggers change nothing.
- R9: In compressed format, if the trigger is pending or asserted in a cycle without a valid PC and the open line holds offsets, that line is flushed with its count tag. Recording stops in that cycle.
- R10: While not recording, valid PCs and triggers write nothing and do not start recording.
- R11: An arm pulse makes the next write go to slot 0 and clears the rollover flag. It also discards the open line and the base, so the next compressed PC becomes a base line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start a fresh trace |
| trig_i | input | 1 | End-aligned trigger request |
| compress_i | input | 1 | 1 = compressed format, 0 = normal format |
| pc_vld_i | input | 1 | PC sample valid |
| pc_i | input | 18 | Program counter |
| dst_i | input | 1 | Address is a destination |
| vec_i | input | 1 | Address is a vector target |
| rd_addr_i | input | 6 | Read slot index |
| rd_line_o | output | 20 | Line stored at `rd_addr_i` |
| wr_ptr_o | output | 6 | Next write slot; oldest line after rollover |
| rollover_o | output | 1 | Sticky wrap indicator |
| active_o | output | 1 | Recording in progress |

## Verification
The hardest case to reach is the double write. In one cycle, a partly filled compressed line must be flushed and a new base line written. The stimulus gets there by packing one offset, then presenting a PC in a different 64-address window, and checking that the pointer jumps by two.

A second case is a trigger that arrives while no line is open, so that stopping is deferred. The bench triggers directly after a base line, feeds an offset that writes nothing, and checks that recording ends only on the following flush-plus-base cycle.

Wraparound is reached by streaming more than DEPTH normal-format lines. The bench then checks the pointer, the oldest entry and the sticky flag.

// File: rtl/pc_trace_pkg.sv
package pc_trace_pkg;
  parameter int PC_W   = 18;
  parameter int OFS_W  = 6;
  parameter int TAG_W  = 2;
  localparam int HI_W   = PC_W - OFS_W;
  localparam int LINE_W = TAG_W + PC_W;

  typedef enum logic [TAG_W-1:0] {
    TAG_BASE  = 2'b00,
    TAG_ONE   = 2'b01,
    TAG_TWO   = 2'b10,
    TAG_THREE = 2'b11
  } trc_tag_e;
endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic trig_i,
  input  logic wrote_i,
  output logic active_o,
  output logic pend_o
);
  logic active_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      pend_q   <= 1'b0;
    end else if (active_q) begin
      if (wrote_i && (pend_q || trig_i)) begin
        active_q <= 1'b0;
        pend_q   <= 1'b0;
      end else if (trig_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign pend_o   = pend_q;

  // R8
  stop_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !arm_i && wrote_i && (pend_q || trig_i)) |=> !active_q);

  // R10
  idle_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !arm_i) |=> !active_q);
endmodule

// File: rtl/trc_packer.sv
module trc_packer
  import pc_trace_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              pc_vld_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              flush_i,
  output logic [1:0]        n_wr_o,
  output logic [LINE_W-1:0] line0_o,
  output logic [LINE_W-1:0] line1_o
);
  localparam int NF = 3;

  logic              base_vld_q;
  logic [HI_W-1:0]   base_hi_q;
  logic [1:0]        cnt_q;
  logic [OFS_W-1:0]  fld_q [NF];
  logic              new_base;
  logic [LINE_W-1:0] open_line;

  assign new_base  = !base_vld_q || (pc_i[PC_W-1:OFS_W] != base_hi_q);
  // tag encoding equals offset count; unused fields held at zero
  assign open_line = {cnt_q, fld_q[2], fld_q[1], fld_q[0]};

  always_comb begin
    n_wr_o  = 2'd0;
    line0_o = '0;
    line1_o = '0;
    if (en_i && pc_vld_i) begin
      if (new_base) begin
        if (cnt_q != 2'd0) begin
          n_wr_o  = 2'd2;
          line0_o = open_line;
          line1_o = {TAG_BASE, pc_i};
        end else begin
          n_wr_o  = 2'd1;
          line0_o = {TAG_BASE, pc_i};
        end
      end else if (cnt_q == 2'd2) begin
        n_wr_o  = 2'd1;
        line0_o = {TAG_THREE, pc_i[OFS_W-1:0], fld_q[1], fld_q[0]};
      end
    end else if (en_i && flush_i && cnt_q != 2'd0) begin
      n_wr_o  = 2'd1;
      line0_o = open_line;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_vld_q <= 1'b0;
      base_hi_q  <= '0;
      cnt_q      <= 2'd0;
      for (int i = 0; i < NF; i++) fld_q[i] <= '0;
    end else if (clr_i) begin
      base_vld_q <= 1'b0;
      cnt_q      <= 2'd0;
      for (int i = 0; i < NF; i++) fld_q[i] <= '0;
    end else if (en_i && pc_vld_i) begin
      if (new_base) begin
        base_vld_q <= 1'b1;
        base_hi_q  <= pc_i[PC_W-1:OFS_W];
        cnt_q      <= 2'd0;
        for (int i = 0; i < NF; i++) fld_q[i] <= '0;
      end else if (cnt_q == 2'd2) begin
        cnt_q <= 2'd0;
        for (int i = 0; i < NF; i++) fld_q[i] <= '0;
      end else begin
        fld_q[cnt_q] <= pc_i[OFS_W-1:0];
        cnt_q        <= cnt_q + 2'd1;
      end
    end else if (en_i && flush_i && cnt_q != 2'd0) begin
      cnt_q <= 2'd0;
      for (int i = 0; i < NF; i++) fld_q[i] <= '0;
    end
  end

  // R4
  open_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != 2'd3);

  // R5
  dual_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_wr_o == 2'd2) |-> (line1_o[LINE_W-1 -: TAG_W] == TAG_BASE &&
                          line0_o[LINE_W-1 -: TAG_W] != TAG_BASE));
endmodule

// File: rtl/trc_ring.sv
module trc_ring
  import pc_trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [1:0]        n_wr_i,
  input  logic [LINE_W-1:0] line0_i,
  input  logic [LINE_W-1:0] line1_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [AW-1:0]     wr_ptr_o,
  output logic              rollover_o
);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [LINE_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     ptr_q, addr1, ptr_nxt;
  logic [AW:0]       sum, inc1;
  logic              wrap, roll_q;

  assign sum     = {1'b0, ptr_q} + (AW+1)'(n_wr_i);
  assign wrap    = sum >= DEPTH_C;
  assign ptr_nxt = wrap ? AW'(sum - DEPTH_C) : sum[AW-1:0];
  assign inc1    = {1'b0, ptr_q} + (AW+1)'(1);
  assign addr1   = (inc1 >= DEPTH_C) ? '0 : inc1[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      roll_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q  <= '0;
      roll_q <= 1'b0;
    end else begin
      ptr_q <= ptr_nxt;
      if (wrap) roll_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (!clr_i && n_wr_i != 2'd0 && ptr_q == AW'(g)) mem_q[g] <= line0_i;
      else if (!clr_i && n_wr_i == 2'd2 && addr1 == AW'(g)) mem_q[g] <= line1_i;
    end
  end

  assign rd_line_o  = ({1'b0, rd_addr_i} < DEPTH_C) ? mem_q[rd_addr_i] : '0;
  assign wr_ptr_o   = ptr_q;
  assign rollover_o = roll_q;

  // R6
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (int'(ptr_q) == (int'($past(ptr_q)) + int'($past(n_wr_i))) % DEPTH));

  // R7
  roll_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roll_q && !clr_i) |=> roll_q);

  // R11
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_q == '0 && !roll_q));
endmodule

// File: rtl/pc_trace_buf.sv
module pc_trace_buf
  import pc_trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              compress_i,
  input  logic              pc_vld_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              dst_i,
  input  logic              vec_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [AW-1:0]     wr_ptr_o,
  output logic              rollover_o,
  output logic              active_o
);
  logic              active, pend, rec, flush;
  logic [1:0]        pk_n, n_wr;
  logic [LINE_W-1:0] pk_l0, pk_l1, nm_line, line0;

  trc_ctrl u_ctrl (
    .clk_i, .rst_ni, .arm_i, .trig_i,
    .wrote_i (n_wr != 2'd0),
    .active_o(active),
    .pend_o  (pend)
  );

  assign rec   = active && !arm_i;
  assign flush = rec && compress_i && (pend || trig_i) && !pc_vld_i;

  trc_packer u_pack (
    .clk_i, .rst_ni,
    .clr_i   (arm_i),
    .en_i    (rec && compress_i),
    .pc_vld_i,
    .pc_i,
    .flush_i (flush),
    .n_wr_o  (pk_n),
    .line0_o (pk_l0),
    .line1_o (pk_l1)
  );

  // vector targets are always destinations
  assign nm_line = {dst_i | vec_i, vec_i, pc_i};
  assign n_wr    = compress_i ? pk_n : ((rec && pc_vld_i) ? 2'd1 : 2'd0);
  assign line0   = compress_i ? pk_l0 : nm_line;

  trc_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni,
    .clr_i     (arm_i),
    .n_wr_i    (n_wr),
    .line0_i   (line0),
    .line1_i   (pk_l1),
    .rd_addr_i,
    .rd_line_o,
    .wr_ptr_o,
    .rollover_o
  );

  assign active_o = active;

  // R2
  vec_dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!compress_i && n_wr != 2'd0 && line0[PC_W]) |-> line0[PC_W+1]);

  // R10
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> n_wr == 2'd0);

  // R8
  frozen_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !arm_i) |=> $stable(wr_ptr_o));
endmodule

// File: tb/sim_pc_trace_buf.sv
module sim_pc_trace_buf;
  localparam int DEPTH = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        arm = 0, trig = 0, comp = 0, vld = 0, dst = 0, vec = 0;
  logic [17:0] pc = '0;
  logic [5:0]  rd_addr = '0;
  logic [19:0] rd_line;
  logic [5:0]  wr_ptr;
  logic        roll, act;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int addr; logic [19:0] line; string req; } exp_t;
  exp_t sb[$];

  pc_trace_buf #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .trig_i(trig), .compress_i(comp),
    .pc_vld_i(vld), .pc_i(pc), .dst_i(dst), .vec_i(vec), .rd_addr_i(rd_addr),
    .rd_line_o(rd_line), .wr_ptr_o(wr_ptr), .rollover_o(roll), .active_o(act)
  );

  always #10 clk = ~clk;

  function automatic logic [19:0] nline(logic [17:0] p, logic d, logic v);
    return {d | v, v, p};
  endfunction
  function automatic logic [19:0] bline(logic [17:0] p);
    return {2'b00, p};
  endfunction
  function automatic logic [19:0] oline(logic [1:0] n, logic [5:0] f2, logic [5:0] f1, logic [5:0] f0);
    return {n, f2, f1, f0};
  endfunction

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // driver side: push expectation
  task automatic expect_line(int a, logic [19:0] l, string req);
    exp_t e;
    e.addr = a; e.line = l; e.req = req;
    sb.push_back(e);
  endtask

  // monitor side: pop and compare against read port
  task automatic drain();
    while (sb.size() > 0) begin
      exp_t e = sb.pop_front();
      rd_addr = 6'(e.addr);
      #1;
      chk(e.req, int'(rd_line), int'(e.line));
    end
  endtask

  // one cycle: set inputs at negedge, return at next negedge
  task automatic cyc(logic v, logic [17:0] p, logic d, logic ve, logic t, logic a);
    vld = v; pc = p; dst = d; vec = ve; trig = t; arm = a;
    @(negedge clk);
    vld = 0; trig = 0; arm = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", int'(wr_ptr), 0);
    chk("R1 roll", int'(roll), 0);
    chk("R1 act", int'(act), 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_line(5, 20'h0, "R1 line");
    drain();

    // R10 idle ignores pc and trigger
    cyc(1, 18'h1111, 0, 0, 0, 0);
    cyc(1, 18'h2222, 1, 0, 1, 0);
    chk("R10 ptr", int'(wr_ptr), 0);
    chk("R10 act", int'(act), 0);
    expect_line(0, 20'h0, "R10 line");
    drain();

    // R2 normal format, R8 trigger with pc
    comp = 0;
    cyc(0, 0, 0, 0, 0, 1);
    chk("R11 act", int'(act), 1);
    cyc(1, 18'h2_1234, 0, 0, 0, 0);
    cyc(1, 18'h1_ABCD, 1, 0, 0, 0);
    cyc(1, 18'h3_0F0F, 0, 1, 0, 0);
    chk("R6 ptr", int'(wr_ptr), 3);
    cyc(1, 18'h0_5555, 1, 1, 1, 0);
    chk("R8 stop", int'(act), 0);
    chk("R8 ptr", int'(wr_ptr), 4);
    cyc(1, 18'h0_7777, 0, 0, 0, 0);
    cyc(1, 18'h0_7778, 0, 0, 1, 0);
    chk("R8 frozen", int'(wr_ptr), 4);
    expect_line(0, nline(18'h2_1234, 0, 0), "R2 l0");
    expect_line(1, nline(18'h1_ABCD, 1, 0), "R2 l1");
    expect_line(2, nline(18'h3_0F0F, 0, 1), "R2 vec forces dst");
    expect_line(3, nline(18'h0_5555, 1, 1), "R8 last");
    expect_line(4, 20'h0, "R8 no write");
    drain();

    // compressed: R3 R4 R5 R9
    comp = 1;
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 18'h12340, 0, 0, 0, 0);
    chk("R3 ptr", int'(wr_ptr), 1);
    cyc(1, 18'h12345, 0, 0, 0, 0);
    cyc(1, 18'h12346, 0, 0, 0, 0);
    chk("R4 no write yet", int'(wr_ptr), 1);
    cyc(1, 18'h12347, 0, 0, 0, 0);
    chk("R4 ptr", int'(wr_ptr), 2);
    cyc(1, 18'h12348, 0, 0, 0, 0);
    cyc(1, 18'h23000, 0, 0, 0, 0);
    chk("R5 double write", int'(wr_ptr), 4);
    cyc(1, 18'h23001, 0, 0, 0, 0);
    cyc(1, 18'h23002, 0, 0, 0, 0);
    chk("R9 act before", int'(act), 1);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R9 stop", int'(act), 0);
    chk("R9 ptr", int'(wr_ptr), 5);
    expect_line(0, bline(18'h12340), "R3 base");
    expect_line(1, oline(2'b11, 6'd7, 6'd6, 6'd5), "R4 three");
    expect_line(2, oline(2'b01, 6'd0, 6'd0, 6'd8), "R5 flush one");
    expect_line(3, bline(18'h23000), "R5 new base");
    expect_line(4, oline(2'b10, 6'd0, 6'd2, 6'd1), "R9 flush two");
    drain();

    // R6 R7 wraparound in normal format
    comp = 0;
    cyc(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH + 3; i++) begin
      cyc(1, 18'(i), 0, 0, 0, 0);
      if (i == DEPTH - 2) chk("R7 not yet", int'(roll), 0);
      if (i == DEPTH - 1) begin
        chk("R6 wrap ptr", int'(wr_ptr), 0);
        chk("R7 set", int'(roll), 1);
      end
    end
    chk("R6 oldest ptr", int'(wr_ptr), 3);
    chk("R7 sticky", int'(roll), 1);
    expect_line(3, nline(18'd3, 0, 0), "R6 oldest");
    expect_line(2, nline(18'(DEPTH + 2), 0, 0), "R6 newest");
    drain();
    cyc(0, 0, 0, 0, 0, 1);
    chk("R7 cleared", int'(roll), 0);
    chk("R11 ptr", int'(wr_ptr), 0);

    // R11 base discarded on arm; R8 deferred stop
    comp = 1;
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 18'h23003, 0, 0, 0, 0);
    chk("R11 base first", int'(wr_ptr), 1);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R8 pending", int'(act), 1);
    cyc(1, 18'h23004, 0, 0, 0, 0);
    chk("R8 append no stop", int'(act), 1);
    cyc(1, 18'h30000, 0, 0, 0, 0);
    chk("R8 deferred stop", int'(act), 0);
    chk("R8 deferred ptr", int'(wr_ptr), 3);
    expect_line(0, bline(18'h23003), "R11 base line");
    expect_line(1, oline(2'b01, 6'd0, 6'd0, 6'd4), "R5 flush");
    expect_line(2, bline(18'h30000), "R5 base");
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule